// File: doc/BRIEF.md
# Store-and-Forward Stream Packet Buffer

This block sits between a stream producer and a stream consumer that use AXI4-Stream style handshakes. It buffers beats that carry a data word and an end-of-packet marker. It releases none of a packet to the consumer until the packet's final beat has been written into the buffer. Once the consumer sees the first beat of a packet, every later beat of that packet is already stored. The packet therefore leaves without any bubble that the buffer could cause.

Each stored word is the end-of-packet flag placed above the data bits. The output is first-word fall-through: the head word is driven on the output whenever output valid is high, with no separate read request. A tally of complete packets held in storage drives output valid. The tally goes up when an accepted input beat carries the end marker, goes down when an accepted output beat carries it, and stays the same when both happen in one cycle.

A small output state machine tracks the packet boundary. In `ST_HEAD` the next output beat starts a packet. An accepted beat without the end marker moves it to `ST_BODY`. In `ST_BODY` an accepted beat with the end marker returns it to `ST_HEAD`; any other cycle stays in the current state. `DEPTH` must be at least the longest packet. A longer packet fills the buffer with no end marker stored, and the buffer then stalls both sides for good.

Top module: `sf_packet_fifo`

## Requirements
- R1: While reset is high, and in the first cycle after it, output valid is 0 and input ready is 1.
- R2: A beat moves on the input side only in a cycle with input valid and input ready both 1. A beat moves on the output side only in a cycle with output valid and output ready both 1.
- R3: Output valid is never 1 unless at least one packet whose end beat has already been accepted on the input is still not fully sent on the output.
- R4: From the first output beat of a packet until that packet's end beat, output valid stays 1 in every cycle.
- R5: Input ready is 0 exactly when `DEPTH` beats are held, and 1 otherwise.
- R6: Output valid is 1 whenever a complete packet is held. A partial packet on its own keeps output valid at 0, even when it fills the buffer.
- R7: Output beats appear in input order, with identical data bits and end-marker bit (`m_last` is bit `DATA_W` of the stored word).
- R8: When an input beat with the end marker and an output beat with the end marker are accepted in the same cycle, the complete-packet tally is unchanged. Output valid then follows R3 and R6.
- R9: While output valid is 1 and output ready is 0, output valid, data and end marker stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Producer offers a beat |
| s_ready | output | 1 | Buffer can accept a beat |
| s_data | input | DATA_W | Input data |
| s_last | input | 1 | Input beat ends its packet |
| m_valid | output | 1 | Head beat is offered to the consumer |
| m_ready | input | 1 | Consumer takes the beat |
| m_data | output | DATA_W | Output data |
| m_last | output | 1 | Output beat ends its packet |

## Verification
The bound checker keeps its own occupancy count and its own complete-packet count, both built from the port handshakes. On every cycle it checks the ready/full relation, that valid follows the complete-packet count, that valid holds inside a packet, and that a stalled output word does not change. Payload order and end-marker placement can be shown only by the bench. It sweeps packet lengths from 1 to the depth against several input-gap and back-pressure patterns, and compares each output beat with a queue built from the accepted input beats. The bench also fills the buffer with one unfinished packet and shows that nothing is released.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic {
        ST_HEAD = 1'b0,
        ST_BODY = 1'b1
    } out_state_e;

    function automatic int unsigned wrap_next(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/sf_store.sv
module sf_store #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    input  logic         rd_en,
    output logic [W-1:0] rd_word,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_en) wr_ptr <= AW'(sf_pkg::wrap_next(int'(wr_ptr), DEPTH));
            if (rd_en) rd_ptr <= AW'(sf_pkg::wrap_next(int'(rd_ptr), DEPTH));
            case ({wr_en, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign rd_word = mem[rd_ptr];
    assign full    = (fill == CW'(DEPTH));
endmodule

// File: rtl/sf_pkt_tally.sv
module sf_pkt_tally #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [PW-1:0] done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   done_q <= done_q + 1'b1;
                2'b01:   done_q <= done_q - 1'b1;
                default: done_q <= done_q;
            endcase
        end
    end

    assign nonzero = (done_q != '0);
endmodule

// File: rtl/sf_out_fsm.sv
module sf_out_fsm (
    input  logic clk,
    input  logic rst,
    input  logic pop,
    input  logic pop_last,
    output logic in_body
);
    import sf_pkg::*;

    out_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HEAD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        in_body = 1'b0;
        unique case (state_q)
            ST_HEAD: begin
                if (pop && !pop_last) state_d = ST_BODY;
            end
            ST_BODY: begin
                in_body = 1'b1;
                if (pop && pop_last) state_d = ST_HEAD;
            end
        endcase
    end
endmodule

// File: rtl/sf_packet_fifo.sv
module sf_packet_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last
);
    localparam int W = DATA_W + 1;

    logic         full, wr_en, rd_en, pkt_ready, body;
    logic [W-1:0] rd_word;

    assign s_ready = !full;
    assign wr_en   = s_valid && s_ready;
    assign m_valid = pkt_ready;
    assign rd_en   = m_valid && m_ready;
    assign m_last  = rd_word[W-1];
    assign m_data  = rd_word[DATA_W-1:0];

    sf_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_word({s_last, s_data}),
        .rd_en(rd_en), .rd_word(rd_word),
        .full(full)
    );

    sf_pkt_tally #(.DEPTH(DEPTH)) u_tally (
        .clk(clk), .rst(rst),
        .inc(wr_en && s_last),
        .dec(rd_en && m_last),
        .nonzero(pkt_ready)
    );

    sf_out_fsm u_fsm (
        .clk(clk), .rst(rst),
        .pop(rd_en), .pop_last(m_last),
        .in_body(body)
    );
endmodule

// File: rtl/sf_packet_fifo_chk.sv
module sf_packet_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              s_valid,
    input logic              s_ready,
    input logic              s_last,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_last,
    input logic              body
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ, pkts;
    logic in_go, out_go;

    assign in_go  = s_valid && s_ready;
    assign out_go = m_valid && m_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ  <= '0;
            pkts <= '0;
        end else begin
            occ  <= occ + CW'(in_go) - CW'(out_go);
            pkts <= pkts + CW'(in_go && s_last) - CW'(out_go && m_last);
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!m_valid && s_ready));

    a_r5_ready_vs_fill: assert property (@(posedge clk) disable iff (rst)
        s_ready == (occ < CW'(DEPTH)));

    a_r3_no_early_release: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (pkts != '0));

    a_r6_complete_offered: assert property (@(posedge clk) disable iff (rst)
        (pkts != '0) |-> m_valid);

    a_r4_no_gap_in_packet: assert property (@(posedge clk) disable iff (rst)
        body |-> m_valid);

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
endmodule

bind sf_packet_fifo sf_packet_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .body(body)
);

// File: tb/tb_sf_packet_fifo.sv
module tb_sf_packet_fifo;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_last = 1'b0;
    logic              m_valid;
    logic              m_ready = 1'b0;
    logic [DATA_W-1:0] m_data;
    logic              m_last;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sf_packet_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit gate(input int p, input int c);
        case (p)
            0:       return 1'b1;
            1:       return (c % 3) != 0;
            2:       return ((c * 5 + 3) % 7) < 3;
            default: return (c % 11) < 2;
        endcase
    endfunction

    function automatic int plen(input int p, input int seed);
        return 1 + ((p * 5 + seed * 3) % DEPTH);
    endfunction

    task automatic do_reset();
        s_valid = 1'b0;
        m_ready = 1'b0;
        s_last  = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        chk(!m_valid, "R1 valid in reset", int'(m_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        chk(!m_valid && s_ready, "R1 after reset", int'({m_valid, s_ready}), 1);
    endtask

    // R2, R3, R4, R5, R6, R7, R8, R9 under one input gap pattern and one back-pressure pattern
    task automatic run_traffic(input int npk, input int seed, input int ip, input int op);
        int qd[0:1023];
        bit ql[0:1023];
        int gp = 0, gb = 0, len, wr_i = 0, rd_i = 0, lin = 0, lout = 0, cyc = 0;
        bit mid = 0, hold = 0, fired = 0, in_fire, out_fire;
        logic [DATA_W:0] held = '0;
        len = plen(0, seed);
        while (lout < npk && cyc < 5000) begin
            @(negedge clk);
            if (fired) s_valid = 1'b0;
            if (!s_valid && gp < npk && gate(ip, cyc)) begin
                s_valid = 1'b1;
                s_data  = DATA_W'(gp * 13 + gb * 7 + seed);
                s_last  = (gb == len - 1);
            end
            m_ready = gate(op, cyc + seed);
            #5;
            chk(s_ready == ((wr_i - rd_i) < DEPTH), "R5 ready vs fill", int'(s_ready), int'((wr_i - rd_i) < DEPTH));
            // R3, R6 and R8: valid equals "a complete packet is held"
            chk(m_valid == (lin > lout), "R3/R6/R8 valid vs packets", int'(m_valid), int'(lin > lout));
            if (mid) chk(m_valid, "R4 gap inside packet", int'(m_valid), 1);
            if (hold) chk({m_last, m_data} == held, "R9 stalled word changed", int'({m_last, m_data}), int'(held));
            in_fire  = s_valid && s_ready;
            out_fire = m_valid && m_ready;
            if (out_fire) begin
                if (rd_i < wr_i) begin
                    chk(m_data == DATA_W'(qd[rd_i]) && m_last == ql[rd_i], "R2/R7 payload order",
                        int'({m_last, m_data}), int'({ql[rd_i], DATA_W'(qd[rd_i])}));
                end else begin
                    chk(1'b0, "R2/R7 beat with nothing queued", rd_i, wr_i);
                end
                rd_i++;
                if (m_last) begin lout++; mid = 0; end
                else mid = 1;
            end
            hold = m_valid && !m_ready;
            held = {m_last, m_data};
            fired = in_fire;
            if (in_fire) begin
                qd[wr_i] = int'(s_data);
                ql[wr_i] = s_last;
                wr_i++;
                if (s_last) begin
                    lin++; gp++; gb = 0; len = plen(gp, seed);
                end else gb++;
            end
            cyc++;
            @(posedge clk);
        end
        chk(lout == npk, "R3 all packets drained", lout, npk);
        @(negedge clk);
        s_valid = 1'b0;
        m_ready = 1'b0;
    endtask

    // R5, R6: an unfinished packet that fills the buffer is never released
    task automatic fill_open();
        for (int i = 0; i < DEPTH + 3; i++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_last  = 1'b0;
            s_data  = DATA_W'(i);
            m_ready = 1'b1;
            #5;
            chk(!m_valid, "R6 partial packet held back", int'(m_valid), 0);
            chk(s_ready == (i < DEPTH), "R5 full with open packet", int'(s_ready), int'(i < DEPTH));
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        for (int ip = 0; ip < 4; ip++) begin
            for (int op = 0; op < 4; op++) begin
                run_traffic(12, ip * 4 + op, ip, op);
            end
        end
        fill_open();
        do_reset();
        run_traffic(16, 1, 0, 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule